// File: doc/BRIEF.md
# Two-Slot Elastic Pipeline Stage

This block is one register stage on an elastic channel that carries data with a valid flag forward and a stop flag backward. A token moves across a channel edge only in a cycle where valid is high and stop is low; valid high with stop high is a retry, and the sender keeps the same data until the token is taken. Valid low means the channel is idle.

The stop that the stage returns to its sender comes from a flip-flop, not from the downstream stop. This breaks the long backward path that would form through a chain of stages and leaves no combinational loop between valid and stop. Because that stop reaches the sender one cycle late, one more token can arrive after the stage decides it must stall. Two storage slots hold that token. Tokens leave in the order they arrived, and the older slot always drives the output data. With the downstream stop held low, the stage passes one token per cycle.

Top module: `elastic_buf2`

## Requirements
- R1: A token is accepted on the input only in a cycle with inValid high and inStop low, and leaves on the output only in a cycle with outValid high and outStop low.
- R2: When outValid is high and outStop is low-inactive is not the case (outStop high), outValid stays high and outData keeps its value in the next cycle.
- R3: outValid is high exactly when the stage holds one or two tokens.
- R4: inStop comes from a register and is high exactly when the stage holds two tokens. It rises in the cycle after occupancy reaches two, which happens when occupancy is one, the output is stalled and an input token is accepted.
- R5: No token is lost when the output stalls. The token that arrives in the cycle the stall begins is stored in the second slot.
- R6: Tokens leave in the order they were accepted, and outData always shows the oldest stored token.
- R7: With outStop low and inValid high every cycle, one token passes per cycle and inStop stays low.
- R8: Synchronous reset empties both slots and drives outValid and inStop low.
- R9: Data offered while inStop is high is not accepted and never appears on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | DATA_W | Data from the sender |
| inValid | input | 1 | Sender offers a token |
| inStop | output | 1 | Registered back-pressure to the sender |
| outData | output | DATA_W | Oldest stored token |
| outValid | output | 1 | Stage holds at least one token |
| outStop | input | 1 | Back-pressure from the receiver |

## Verification
The bench keeps its own occupancy model and a queue of accepted tokens. It checks every output transfer against the queue head. This catches a stage that drops the token arriving in the cycle the stall begins, because the sequence would skip a value. It also catches a stage that reads the newer slot, because values would come out swapped. Directed phases fill the stage against a held stop so that inStop must rise after the second token. During that stop, fresh data is offered; a stage that took it would show an extra value in the sequence. A free-running phase requires one token per cycle, so a stage that stalls needlessly at an occupancy of one shows up as lost throughput. A mid-stream reset is also applied; a stage that kept stale tokens would present outValid high after the reset.

// File: rtl/ebuf_pkg.sv
package ebuf_pkg;
  localparam int SLOTS = 2;
  localparam int PTR_W = 1;
  localparam int OCC_W = $clog2(SLOTS + 1);

  typedef struct packed {
    logic wrEn;   // store the incoming token in the write slot
    logic rdEn;   // retire the oldest token
  } ctrlStrobes_t;
endpackage

// File: rtl/ebuf_ctrl.sv
module ebuf_ctrl
  import ebuf_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic         outStop,
  output logic         inStop,
  output logic         outValid,
  output ctrlStrobes_t strobes
);
  logic [OCC_W-1:0] occ, occNext;
  logic stopReg;
  logic inXfer, outXfer;

  assign inXfer  = inValid && !stopReg;
  assign outXfer = (occ != '0) && !outStop;

  always_comb begin
    occNext = occ;
    case ({inXfer, outXfer})
      2'b10:   occNext = occ + 1'b1;
      2'b01:   occNext = occ - 1'b1;
      default: occNext = occ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ     <= '0;
      stopReg <= 1'b0;
    end else begin
      occ     <= occNext;
      stopReg <= (occNext == OCC_W'(SLOTS));
    end
  end

  assign inStop       = stopReg;
  assign outValid     = (occ != '0);
  assign strobes.wrEn = inXfer;
  assign strobes.rdEn = outXfer;

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_W'(SLOTS)) && inValid |-> inStop);

  // R4
  stop_on_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_W'(1)) && inXfer && outStop |=> inStop && outValid);

  // R7
  steady_flow_chk: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_W'(1)) && inXfer && !outStop |=> !inStop && outValid);
endmodule

// File: rtl/ebuf_dp.sv
module ebuf_dp
  import ebuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0] slot [SLOTS];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobes.wrEn) wrPtr <= wrPtr + 1'b1;
      if (strobes.rdEn) rdPtr <= rdPtr + 1'b1;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (strobes.wrEn && (wrPtr == PTR_W'(s))) slot[s] <= inData;
    end
  end

  assign outData = slot[rdPtr];

  // R6
  order_adv_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.rdEn |=> rdPtr != $past(rdPtr));
endmodule

// File: rtl/elastic_buf2.sv
module elastic_buf2
  import ebuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inStop,
  output logic [DATA_W-1:0] outData,
  output logic              outValid,
  input  logic              outStop
);
  ctrlStrobes_t strobes;

  ebuf_ctrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .outStop(outStop),
    .inStop(inStop), .outValid(outValid), .strobes(strobes)
  );

  ebuf_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rst(rst), .strobes(strobes),
    .inData(inData), .outData(outData)
  );

  // R2
  retry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && outStop |=> outValid && $stable(outData));
endmodule

// File: tb/elastic_buf2_tb_top.sv
module elastic_buf2_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst;
  logic [DW-1:0] inData;
  logic inValid, outStop;
  logic inStop, outValid;
  logic [DW-1:0] outData;

  int checks = 0;
  int bad = 0;
  int modelOcc = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] seqVal = 8'd1;
  int outCount = 0;
  logic prevHold = 1'b0;
  logic [DW-1:0] prevData = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  elastic_buf2 #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid),
    .inStop(inStop), .outData(outData), .outValid(outValid), .outStop(outStop)
  );

  function automatic logic expValid(int occ);
    return occ > 0;
  endfunction

  function automatic logic expStop(int occ);
    return occ == 2;
  endfunction

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive at negedge, evaluate before the next posedge
  task automatic step(input logic v, input logic st);
    logic ix, ox;
    @(negedge clk);
    inValid = v;
    outStop = st;
    inData  = (v && !inStop) ? seqVal : (v ? seqVal : 8'hEE);
    #1;
    chk(outValid == expValid(modelOcc), "R3 outValid vs occupancy", outValid, expValid(modelOcc));
    chk(inStop == expStop(modelOcc), "R4 inStop vs occupancy", inStop, expStop(modelOcc));
    if (prevHold) begin
      chk(outValid && outData == prevData, "R2 retry hold", outData, prevData);
    end
    ix = inValid && !inStop;
    ox = outValid && !outStop;
    if (ox) begin
      chk(q.size() > 0 && outData == q[0], "R6 order / R5 no loss", outData,
          q.size() > 0 ? q[0] : -1);
      if (q.size() > 0) void'(q.pop_front());
      outCount++;
    end
    if (ix) begin
      q.push_back(seqVal);
      seqVal = seqVal + 1'b1;
    end
    modelOcc = modelOcc + (ix ? 1 : 0) - (ox ? 1 : 0);
    prevHold = outValid && outStop;
    prevData = outData;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1; inValid = 1'b0; outStop = 1'b0; inData = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    #1;
    chk(outValid == 1'b0, "R8 reset outValid", outValid, 0);
    chk(inStop == 1'b0, "R8 reset inStop", inStop, 0);
    modelOcc = 0; q.delete(); prevHold = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    #(CLK_PERIOD * 50000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    int startCnt;
    int qBefore;
    void'($urandom(32'd1234));
    doReset();

    // R7: full throughput
    step(1'b1, 1'b0);
    startCnt = outCount;
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0);
    chk(outCount - startCnt == 40, "R7 one token per cycle", outCount - startCnt, 40);

    // R4/R5: stall with one token inside, next token must be absorbed
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    #1;
    chk(inStop == 1'b1, "R4 stop after fill", inStop, 1);
    chk(q.size() == 2, "R5 two tokens held", q.size(), 2);

    // R9: offers during stop are ignored
    qBefore = q.size();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
    chk(q.size() == qBefore, "R9 no accept under stop", q.size(), qBefore);
    chk(outValid == 1'b1, "R1 no output under outStop", outValid, 1);

    // drain
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    chk(outValid == 1'b0, "R3 empty after drain", outValid, 0);

    // random phase
    for (int i = 0; i < 3000; i++)
      step(($urandom % 4) != 0, ($urandom % 3) == 0);

    // R8: mid-stream reset with tokens inside
    step(1'b1, 1'b1);
    step(1'b1, 1'b1);
    doReset();
    step(1'b0, 1'b0);
    chk(outValid == 1'b0, "R8 empty after reset", outValid, 0);

    for (int i = 0; i < 2000; i++)
      step(($urandom % 2) != 0, ($urandom % 2) == 0);
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0);
    chk(q.size() == 0, "R1 all tokens delivered", q.size(), 0);

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule